// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block turns single-word read and write requests from a host into the strobe sequences of a two-bank EDO DRAM module that stores 36-bit words. Each access opens one row, strobes one column and then closes the row again. The row half and the column half of the word address share one multiplexed address bus. Only one of the two active-low row strobes falls, and that choice selects the bank. Four active-low column strobes act as 9-bit byte-lane enables. Every write is an early write: the write enable falls one cycle before the column strobes do, so the memory never drives the data bus during a write.

The host side uses a valid/ready request. `req_ready` is high only while the controller is idle and no refresh is pending. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. Its address, write flag, data and lane enables need to be valid only at that edge. A host that sees `req_ready` low holds its request until it is taken. Read data returns as a single-cycle `rd_valid` pulse and cannot be stalled.

Refresh and power-up initialization are done by an external agent. That agent raises `ref_req`. The controller answers with `ref_gnt`, but only from idle, and it keeps every strobe inactive while the grant is held. All strobe timings are cycle counts, rounded up from nanosecond parameters and the clock period. The default values match a 60 ns part at a 4 ns clock.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, both row strobes, all four column strobes and the write enable are high, the data output enable is low, `rd_valid` and `ref_gnt` are low, and `req_ready` is high when `ref_req` is low.
- R2: `req_ready` is high exactly when the controller is idle and `ref_req` is low. A request is accepted on the edge where `req_valid` and `req_ready` are both high, and requests presented at any other time have no effect.
- R3: The word address is split as follows: bank = bit 22, row = bits 21..11, column = bits 10..0. `dram_ma` carries the row from the first cycle after acceptance through the last cycle before the column-setup cycle. It carries the column from that setup cycle until the strobes rise.
- R4: Only the row strobe of the addressed bank falls (`dram_ras_n[0]` for bank 0, `dram_ras_n[1]` for bank 1). It falls in the second cycle after acceptance and stays low for 15 cycles (≥60 ns). The row-strobe-to-column-strobe delay is 11 cycles: 10 cycles with the row address, then 1 column-setup cycle.
- R5: The column strobes stay low for 4 cycles (≥15 ns). They rise on the same edge as the row strobe, and they are never low while both row strobes are high.
- R6: In a write, `dram_we_n` is low and `dram_dq_oe` is high from the column-setup cycle until the strobes rise (5 cycles). `dram_dq_out` equals the accepted write data. Only the column strobes whose lane enable is set fall, where lane i covers data bits 9i+8..9i.
- R7: In a read, `dram_we_n` stays high, `dram_dq_oe` stays low and all four column strobes fall. `rd_valid` pulses for one cycle, in the first cycle after the strobes rise, with `rd_data` equal to `dram_dq_in` in the last column-strobe cycle.
- R8: After the strobes rise, both row strobes stay high for a 12-cycle precharge before the controller is idle again. The full access cycle is 28 cycles or more (≥110 ns).
- R9: `ref_gnt` rises only from idle, and it wins over a host request that arrives in the same cycle. A `ref_req` raised during an access waits until that access and its precharge have finished. While `ref_gnt` is high, all strobes are inactive and no host request is accepted. When `ref_req` falls, a 12-cycle precharge follows before the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {bank, row, column} |
| req_wdata | input | 36 | Write data |
| req_be | input | 4 | Byte-lane enables for writes |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 36 | Read data |
| ref_req | input | 1 | Refresh agent asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh agent |
| dram_ma | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, one per bank, active low |
| dram_cas_n | output | 4 | Column strobes, one per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_in | input | 36 | Data from the memory |
| dram_dq_out | output | 36 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |

## Verification
The hardest case to reach is a refresh request that collides with host traffic. The request can arrive in the same cycle as a host request, or partway through an access, where it must wait for the access and the whole precharge. The stimulus raises `ref_req` at fixed cycle offsets after a request has been accepted, and also together with a pending request while idle. It keeps a host request waiting during the grant, so the deferred grant, the blocked `req_ready` and the precharge after release all show up at the pins. A behavioural memory on the pins latches the row and column from the strobes, so any address-split or lane error comes back as wrong read data.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ASU, ST_ROW, ST_COLA, ST_COL, ST_PRE, ST_REF
  } edo_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_BITS = 11,
  parameter int COL_BITS = 11,
  parameter int MA_W     = 11
) (
  input  logic [ROW_BITS+COL_BITS:0] addr,
  input  logic                       sel_col,
  output logic                       bank,
  output logic [MA_W-1:0]            ma
);
  logic [MA_W-1:0] row_x, col_x;

  assign bank  = addr[ROW_BITS+COL_BITS];
  assign row_x = MA_W'(addr[ROW_BITS+COL_BITS-1:COL_BITS]);
  assign col_x = MA_W'(addr[COL_BITS-1:0]);
  assign ma    = sel_col ? col_x : row_x;
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_BITS  = 11,
  parameter int COL_BITS  = 11,
  parameter int DATA_W    = 36,
  parameter int LANES     = 4,
  parameter int CLK_PS    = 4000,
  parameter int T_RAC_PS  = 60000,
  parameter int T_CAC_PS  = 15000,
  parameter int T_RC_PS   = 110000,
  parameter int T_RP_PS   = 40000,
  parameter int T_RCD_PS  = 20000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ROW_BITS+COL_BITS:0]        req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  input  logic [LANES-1:0]                  req_be,
  output logic                              rd_valid,
  output logic [DATA_W-1:0]                 rd_data,
  input  logic                              ref_req,
  output logic                              ref_gnt,
  output logic [imax(ROW_BITS,COL_BITS)-1:0] dram_ma,
  output logic [1:0]                        dram_ras_n,
  output logic [LANES-1:0]                  dram_cas_n,
  output logic                              dram_we_n,
  input  logic [DATA_W-1:0]                 dram_dq_in,
  output logic [DATA_W-1:0]                 dram_dq_out,
  output logic                              dram_dq_oe
);
  localparam int ADDR_W  = ROW_BITS + COL_BITS + 1;
  localparam int MA_W    = imax(ROW_BITS, COL_BITS);
  localparam int NBANK   = 2;
  localparam int RAC_CYC = ceil_div(T_RAC_PS, CLK_PS);
  localparam int CAS_CYC = imax(1, ceil_div(T_CAC_PS, CLK_PS));
  localparam int RC_CYC  = ceil_div(T_RC_PS, CLK_PS);
  // row phase stretched so the row strobe stays low for the full row access time
  localparam int ROW_CYC = imax(imax(1, ceil_div(T_RCD_PS, CLK_PS)), RAC_CYC - 1 - CAS_CYC);
  localparam int RAS_LOW_CYC = ROW_CYC + 1 + CAS_CYC;
  // precharge stretched so the whole cycle (incl. one address setup cycle) meets tRC
  localparam int PRE_CYC = imax(imax(1, ceil_div(T_RP_PS, CLK_PS)), RC_CYC - RAS_LOW_CYC - 1);
  localparam int CNT_MAX = imax(ROW_CYC, imax(CAS_CYC, PRE_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  edo_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [LANES-1:0]  be_q;
  logic              accept;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              sel_col, bank, ras_phase;

  assign req_ready = (state_q == ST_IDLE) && !ref_req;
  assign accept    = req_valid && req_ready;
  assign ref_gnt   = (state_q == ST_REF);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_req)        state_d = ST_REF;
        else if (req_valid) state_d = ST_ASU;
      end
      ST_ASU: begin
        state_d  = ST_ROW;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(ROW_CYC - 1);
      end
      ST_ROW:  if (tmr_done) state_d = ST_COLA;
      ST_COLA: begin
        state_d  = ST_COL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CAS_CYC - 1);
      end
      ST_COL: begin
        if (tmr_done) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PRE_CYC - 1);
        end
      end
      ST_PRE:  if (tmr_done) state_d = ST_IDLE;
      ST_REF: begin
        if (!ref_req) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PRE_CYC - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      be_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state_q  <= state_d;
      rd_valid <= (state_q == ST_COL) && tmr_done && !wr_q;
      if ((state_q == ST_COL) && tmr_done && !wr_q) rd_data <= dram_dq_in;
      if (accept) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        wd_q   <= req_wdata;
        be_q   <= req_be;
      end
    end
  end

  edo_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign sel_col = (state_q == ST_COLA) || (state_q == ST_COL);

  edo_addr_mux #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .MA_W(MA_W)) u_amux (
    .addr(addr_q), .sel_col(sel_col), .bank(bank), .ma(dram_ma)
  );

  assign ras_phase = (state_q == ST_ROW) || sel_col;

  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    assign dram_ras_n[b] = !(ras_phase && (bank == 1'(b)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cas
    assign dram_cas_n[l] = !((state_q == ST_COL) && (!wr_q || be_q[l]));
  end

  assign dram_we_n   = !(wr_q && sel_col);
  assign dram_dq_oe  = wr_q && sel_col;
  assign dram_dq_out = wd_q;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int LANES   = 4,
  parameter int RAS_MIN = 15,
  parameter int PRE_MIN = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             rd_valid,
  input logic [1:0]       dram_ras_n,
  input logic [LANES-1:0] dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_dq_oe
);
  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= 8'hFF;
    end else if (dram_ras_n != 2'b11) begin
      lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
    end
  end

  p_one_bank_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(~dram_ras_n) <= 1);
  p_ras_width_r4: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n == 2'b11 && $past(dram_ras_n) != 2'b11) |-> (lo_cnt >= 8'(RAS_MIN)));
  p_cas_in_ras_r5: assert property (@(posedge clk) disable iff (rst)
    (dram_cas_n != '1) |-> (dram_ras_n != 2'b11));
  p_oe_write_r6: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> !dram_we_n);
  p_we_held_r6: assert property (@(posedge clk) disable iff (rst)
    (dram_cas_n != '1 && $past(dram_cas_n) != '1) |-> $stable(dram_we_n));
  p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n != 2'b11 && $past(dram_ras_n) == 2'b11) |-> (hi_cnt >= 8'(PRE_MIN)));
  p_gnt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (dram_ras_n == 2'b11 && dram_cas_n == '1 && dram_we_n));
  p_ready_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ref_req && !ref_gnt && dram_ras_n == 2'b11));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .LANES(LANES), .RAS_MIN(RAS_LOW_CYC), .PRE_MIN(PRE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .rd_valid(rd_valid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  // phase numbers counted from the acceptance edge (phase 1 = cycle after it)
  localparam int PH_ROW0 = 2, PH_COLA = 12, PH_COL0 = 13, PH_COL1 = 16;
  localparam int PH_PRE0 = 17, PH_LAST = 28;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [22:0] req_addr = '0;
  logic [35:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rd_valid, ref_gnt, dram_we_n, dram_dq_oe;
  logic [35:0] rd_data, dram_dq_out;
  logic [35:0] dram_dq_in = '0;
  logic [10:0] dram_ma;
  logic [1:0]  dram_ras_n;
  logic [3:0]  dram_cas_n;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  edo_dram_ctrl u_edo_dram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ma(dram_ma), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_in(dram_dq_in), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe)
  );

  always #2 clk = ~clk;

  function automatic logic [35:0] fill(input logic [22:0] a);
    return {a ^ 23'h5A5A5, 13'h1ABC};
  endfunction

  logic [35:0] ref_mem [int];
  logic [35:0] pin_mem [int];

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  int          ph = 0;
  logic        m_wr = 1'b0, m_rdv = 1'b0;
  logic [22:0] m_addr = '0;
  logic [35:0] m_wd = '0, m_exp = '0;
  logic [3:0]  m_be = '0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; m_rdv = 1'b0;
    end else begin
      m_rdv = (ph == PH_COL1) && !m_wr;
      if (ph == 0) begin
        if (ref_req) ph = -1;
        else if (req_valid) begin
          logic [35:0] old;
          m_wr = req_write; m_addr = req_addr; m_wd = req_wdata; m_be = req_be;
          old = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : fill(req_addr);
          if (req_write) begin
            for (int l = 0; l < 4; l++) if (req_be[l]) old[9*l +: 9] = req_wdata[9*l +: 9];
            ref_mem[int'(req_addr)] = old;
          end else m_exp = old;
          ph = 1;
        end
      end else if (ph == -1) begin
        if (!ref_req) ph = PH_PRE0;
      end else if (ph == PH_LAST) ph = 0;
      else ph++;
    end
  end

  // pin-level memory and per-cycle comparison, away from the rising edge
  logic [1:0]  p_ras_prev = 2'b11;
  logic [3:0]  p_cas_prev = 4'hF;
  logic        p_bank = 1'b0;
  logic [10:0] p_row = '0, p_col = '0;

  always @(negedge clk) begin
    int key;
    cyc++;
    if (dram_ras_n != 2'b11 && p_ras_prev == 2'b11) begin
      p_bank = !dram_ras_n[1]; p_row = dram_ma;
    end
    key = int'({p_bank, p_row, dram_ma});
    if (dram_cas_n != 4'hF && p_cas_prev == 4'hF) begin
      p_col = dram_ma;
      key = int'({p_bank, p_row, p_col});
      if (!dram_we_n) begin
        logic [35:0] w;
        w = pin_mem.exists(key) ? pin_mem[key] : fill(23'(key));
        for (int l = 0; l < 4; l++) if (!dram_cas_n[l]) w[9*l +: 9] = dram_dq_out[9*l +: 9];
        pin_mem[key] = w;
      end
    end
    key = int'({p_bank, p_row, p_col});
    dram_dq_in = (dram_cas_n != 4'hF && dram_we_n) ?
                 (pin_mem.exists(key) ? pin_mem[key] : fill(23'(key))) : 36'h0;
    p_ras_prev = dram_ras_n; p_cas_prev = dram_cas_n;

    begin
      logic [1:0] e_ras; logic [3:0] e_cas; logic e_we; bit in_ras;
      in_ras = (ph >= PH_ROW0 && ph <= PH_COL1);
      e_ras  = in_ras ? (m_addr[22] ? 2'b01 : 2'b10) : 2'b11;
      e_cas  = (ph >= PH_COL0 && ph <= PH_COL1) ? (m_wr ? ~m_be : 4'h0) : 4'hF;
      e_we   = !(m_wr && ph >= PH_COLA && ph <= PH_COL1);
      cmp((ph >= PH_PRE0) ? "R8 ras_n precharge" : "R4 ras_n", 64'(dram_ras_n), 64'(e_ras));
      cmp(m_wr ? "R6 cas_n lanes" : "R5 cas_n", 64'(dram_cas_n), 64'(e_cas));
      cmp(m_wr ? "R6 we_n" : "R7 we_n", 64'(dram_we_n), 64'(e_we));
      cmp("R6 dq_oe", 64'(dram_dq_oe), 64'(!e_we));
      if (!e_we) cmp("R6 dq_out", 64'(dram_dq_out), 64'(m_wd));
      if (ph >= 1 && ph < PH_COLA) cmp("R3 row addr", 64'(dram_ma), 64'(m_addr[21:11]));
      if (ph >= PH_COLA && ph <= PH_COL1) cmp("R3 col addr", 64'(dram_ma), 64'(m_addr[10:0]));
      cmp(ref_req ? "R9 ready blocked" : "R2 ready", 64'(req_ready), 64'(ph == 0 && !ref_req));
      cmp("R9 ref_gnt", 64'(ref_gnt), 64'(ph == -1));
      cmp("R7 rd_valid", 64'(rd_valid), 64'(m_rdv));
      if (m_rdv) cmp("R7 rd_data", 64'(rd_data), 64'(m_exp));
    end

    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // called just after a falling edge; returns just after a falling edge
  task automatic issue(input logic wr, input logic [22:0] a, input logic [35:0] d, input logic [3:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset state at the pins
    cmp("R1 ras_n", 64'(dram_ras_n), 64'h3);
    cmp("R1 cas_n", 64'(dram_cas_n), 64'hF);
    cmp("R1 we_n/oe", 64'({dram_we_n, dram_dq_oe}), 64'h2);
    cmp("R1 ready/gnt/rdv", 64'({req_ready, ref_gnt, rd_valid}), 64'h4);
    rst = 1'b0;
    idle(1);
    cmp("R1 first cycle ready", 64'(req_ready), 64'h1);

    issue(1'b1, 23'h000123, 36'hA_BCDE_F012, 4'hF);         // bank 0 full write
    issue(1'b0, 23'h000123, '0, 4'h0);                      // R7 read back
    issue(1'b1, 23'h7FF801, 36'h1_2345_6789, 4'b0101);      // R6 partial lanes, bank 1
    issue(1'b0, 23'h7FF801, '0, 4'h0);
    issue(1'b0, 23'h2AAAAA, '0, 4'h0);                      // untouched word
    idle(35);

    // R9: refresh at idle blocks a waiting request
    ref_req = 1'b1;
    idle(3);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 23'h400000; req_wdata = 36'hF_0F0F_0F0F; req_be = 4'b1000;
    idle(20);
    ref_req = 1'b0;
    issue(1'b1, 23'h400000, 36'hF_0F0F_0F0F, 4'b1000);

    // R9: refresh raised during an access waits for it
    fork
      issue(1'b0, 23'h400000, '0, 4'h0);
      begin idle(6); ref_req = 1'b1; idle(40); ref_req = 1'b0; end
    join

    // R9: refresh and request in the same cycle
    idle(30);
    ref_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 23'h000001;
    idle(8);
    ref_req = 1'b0;
    issue(1'b0, 23'h000001, '0, 4'h0);

    // R3/R8: back-to-back corner addresses
    issue(1'b1, 23'h7FFFFF, 36'hF_FFFF_FFFF, 4'b0010);
    issue(1'b1, 23'h000000, 36'h0_0000_0000, 4'b1001);
    issue(1'b0, 23'h7FFFFF, '0, 4'h0);
    issue(1'b0, 23'h000000, '0, 4'h0);
    issue(1'b1, 23'h3FF800, 36'h5_A5A5_A5A5, 4'hF);
    issue(1'b0, 23'h3FF800, '0, 4'h0);
    issue(1'b0, 23'h0007FF, '0, 4'h0);
    idle(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule